// File: doc/BRIEF.md
# I2C Slave Bridge to Mixed-Width Memory Regions

This block is an I2C slave that lets an external bus master read and write several internal memories and register banks through one two-wire port. SCL is only ever an input. The slave touches SDA only by pulling it low, and an external pull-up supplies the high level. The 7-bit device address is a fixed six-bit prefix followed by the level of the `addr_pin` strap, so two copies of the block can share one bus.

After a write-direction device address, the master sends a 16-bit memory address as two bytes, high byte first. Data words follow. The number of bytes in each word is not configured by software. The slave decodes it from the current memory address: 24-bit regions move three bytes per word and 16-bit regions move two. Reads use the combined format: a write phase sets the address, then a repeated START and the device address with the read bit. After every complete word the internal address advances by one, and the width is decoded again for the new address, so a burst may cross from a 24-bit region into a 16-bit one.

On the memory side the block drives a plain parallel bus. `bus_we` is a one-cycle valid strobe with no ready, because the target must take every write. `bus_re` is a one-cycle request, and the target must present the word on `bus_rdata` in the following cycle. The bus has no back-pressure. The I2C pace, many clock cycles per bit, leaves room for both transfers.

Top module: `i2c_region_bridge`

## Requirements
- R1: The slave acknowledges a device address byte only when its upper seven bits equal `0011100` with bit 1 replaced by `addr_pin` (write byte 0x38 or read byte 0x39 with the pin low, 0x3A or 0x3B with it high). Any other address gets no acknowledge, and the rest of that transfer causes no bus activity.
- R2: After an acknowledged write-direction address, the next two bytes are acknowledged and set the memory address, high byte first.
- R3: Word width is decoded from the memory address:
  - 3 bytes for 0x0000–0x0FFE and for the window 0x2000–0x200F.
  - 2 bytes for 0x0FFF, for 0x1000–0x1FFF and for every unmapped address (0x2010 and above).
  - Bytes travel most significant first.
  - A 16-bit word sits in bits [15:0] of the bus data, and bits [23:16] are zero on writes.
- R4: Each completed write word gives exactly one `bus_we` pulse carrying its address and data. The address then advances by one, and the next word's width follows the new address.
- R5: In a read, each word is fetched with a single-cycle `bus_re` pulse, and `bus_rdata` is taken in the cycle after it. `bus_we` and `bus_re` are never high together.
- R6: In a read burst, each word the master acknowledges in full advances the address by one. The next word is then fetched and sent with its own decoded width.
- R7: A NACK from the master ends the read. SDA stays released, and no further `bus_re` is issued.
- R8: Every byte after a matching device address is acknowledged, whatever the memory address. Unmapped addresses never raise `bus_we` or `bus_re`, and reads from them return zero bytes. The window 0x2000–0x200F always strobes the bus.
- R9: A START or STOP at any point returns the slave to address reception. A partly received word is discarded without a strobe, and the memory address is kept.
- R10: `sda_pull` (1 means drive SDA low) changes only while the synchronised SCL is low.
- R11: While `rst_n` is low, `sda_pull`, `bus_we` and `bus_re` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | I2C clock line as seen on the pad |
| sda_in | input | 1 | I2C data line as seen on the pad |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_pin | input | 1 | Strap selecting the lowest device address bit |
| bus_addr | output | 16 | Memory word address |
| bus_wdata | output | 24 | Write word, right-aligned |
| bus_we | output | 1 | One-cycle write strobe |
| bus_re | output | 1 | One-cycle read request |
| bus_rdata | input | 24 | Read word, valid the cycle after `bus_re` |

## Verification
The assertions assume the master changes SDA only while SCL is low, except when it forms a START or STOP. They also assume each SCL phase lasts well beyond the synchroniser delay, and that nothing but a START or STOP interrupts the slave while it drives SDA. The stimulus meets these assumptions by design:
- The bench master splits every bit into four ten-cycle quarters and moves SDA only in the quarter after SCL falls.
- It issues START and STOP only when the slave has released the line.
- Its memory model answers each `bus_re` with a registered word, so data arrives exactly one cycle later.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  localparam int unsigned MA_W = 16;
  localparam int unsigned WD_W = 24;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
  } link_st_e;

  // Byte idx of a word, most significant first; wide selects 3-byte words.
  function automatic logic [7:0] pick_byte(input logic [WD_W-1:0] w,
                                           input logic wide,
                                           input logic [1:0] idx);
    case ({wide, idx})
      3'b100:  return w[23:16];
      3'b101:  return w[15:8];
      3'b110:  return w[7:0];
      3'b000:  return w[15:8];
      3'b001:  return w[7:0];
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_in};
      sda_q <= {sda_q[STAGES-2:0], sda_in};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cb_region.sv
module i2cb_region #(
  parameter int             AW       = 16,
  parameter logic [AW-1:0]  X_LAST   = 'h0FFE,
  parameter logic [AW-1:0]  CTRL_AT  = 'h0FFF,
  parameter logic [AW-1:0]  Y_FIRST  = 'h1000,
  parameter logic [AW-1:0]  Y_LAST   = 'h1FFF,
  parameter logic [AW-1:0]  WIN_BASE = 'h2000,
  parameter int             WIN_SIZE = 16
) (
  input  logic [AW-1:0] addr,
  output logic          wide,
  output logic          mapped
);
  localparam logic [AW-1:0] WIN_LAST = AW'(WIN_BASE + AW'(WIN_SIZE - 1));

  logic in_x, in_ctrl, in_y, in_win;

  assign in_x    = (addr <= X_LAST);
  assign in_ctrl = (addr == CTRL_AT);
  assign in_y    = (addr >= Y_FIRST) && (addr <= Y_LAST);
  assign in_win  = (addr >= WIN_BASE) && (addr <= WIN_LAST);

  assign wide   = in_x | in_win;
  assign mapped = in_x | in_ctrl | in_y | in_win;
endmodule

// File: rtl/i2c_region_bridge.sv
module i2c_region_bridge
  import i2cb_pkg::*;
#(
  parameter logic [5:0] DEV_PREFIX  = 6'b001110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            sda_pull,
  input  logic            addr_pin,
  output logic [MA_W-1:0] bus_addr,
  output logic [WD_W-1:0] bus_wdata,
  output logic            bus_we,
  output logic            bus_re,
  input  logic [WD_W-1:0] bus_rdata
);
  localparam logic [MA_W-1:0] ONE_A = 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic cur_wide, cur_mapped, last_byte;

  link_st_e        st;
  logic [2:0]      bit_cnt;
  logic            byte_done, rw;
  logic [7:0]      rx_sr, tx_sr, addr_hi, nxt_byte;
  logic [1:0]      rx_idx, bi;
  logic [15:0]     wacc;
  logic [WD_W-1:0] word_buf;
  logic            adv, adv_fetch, fetch_req, ld_go, ld_go2, ld_map;

  i2cb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cb_region #(.AW(MA_W)) u_dec (
    .addr(bus_addr), .wide(cur_wide), .mapped(cur_mapped)
  );

  assign last_byte = cur_wide ? (bi == 2'd2) : (bi == 2'd1);
  assign nxt_byte  = pick_byte(word_buf, cur_wide, bi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      byte_done <= 1'b0;
      rw        <= 1'b0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      addr_hi   <= '0;
      rx_idx    <= '0;
      bi        <= '0;
      wacc      <= '0;
      word_buf  <= '0;
      adv       <= 1'b0;
      adv_fetch <= 1'b0;
      fetch_req <= 1'b0;
      ld_go     <= 1'b0;
      ld_go2    <= 1'b0;
      ld_map    <= 1'b0;
      sda_pull  <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
    end else begin
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      adv       <= 1'b0;
      fetch_req <= 1'b0;
      ld_go     <= 1'b0;
      ld_go2    <= ld_go;

      // address advance and read fetch pipeline
      if (adv) begin
        bus_addr  <= bus_addr + ONE_A;
        fetch_req <= adv_fetch;
      end
      if (fetch_req) begin
        bus_re <= cur_mapped;
        ld_map <= cur_mapped;
        ld_go  <= 1'b1;
      end
      if (ld_go2) word_buf <= ld_map ? bus_rdata : '0;

      // bus conditions, then SCL edges
      if (stop_det) begin
        st        <= ST_IDLE;
        sda_pull  <= 1'b0;
        byte_done <= 1'b0;
      end else if (start_det) begin
        st        <= ST_DEV;
        bit_cnt   <= '0;
        byte_done <= 1'b0;
        sda_pull  <= 1'b0;
        rx_idx    <= '0;
        bi        <= '0;
      end else if (scl_rise) begin
        case (st)
          ST_DEV, ST_RX: begin
            rx_sr   <= {rx_sr[6:0], sda_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) byte_done <= 1'b1;
          end
          ST_TX: begin
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) byte_done <= 1'b1;
          end
          ST_DEV_ACK: if (rw) fetch_req <= 1'b1;
          ST_TX_ACK: begin
            if (sda_s) begin
              st <= ST_IDLE;
            end else if (last_byte) begin
              bi        <= '0;
              adv       <= 1'b1;
              adv_fetch <= 1'b1;
            end else begin
              bi <= bi + 2'd1;
            end
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        case (st)
          ST_DEV: if (byte_done) begin
            byte_done <= 1'b0;
            rw        <= rx_sr[0];
            if (rx_sr[7:1] == {DEV_PREFIX, addr_pin}) begin
              sda_pull <= 1'b1;
              st       <= ST_DEV_ACK;
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_DEV_ACK: begin
            bit_cnt <= '0;
            bi      <= '0;
            if (rw) begin
              st       <= ST_TX;
              tx_sr    <= nxt_byte;
              sda_pull <= ~nxt_byte[7];
            end else begin
              st       <= ST_RX;
              sda_pull <= 1'b0;
              rx_idx   <= '0;
            end
          end
          ST_RX: if (byte_done) begin
            byte_done <= 1'b0;
            sda_pull  <= 1'b1;
            st        <= ST_RX_ACK;
            case (rx_idx)
              2'd0: begin
                addr_hi <= rx_sr;
                rx_idx  <= 2'd1;
              end
              2'd1: begin
                bus_addr <= {addr_hi, rx_sr};
                rx_idx   <= 2'd2;
                bi       <= '0;
              end
              default: begin
                wacc <= {wacc[7:0], rx_sr};
                if (last_byte) begin
                  bi        <= '0;
                  bus_we    <= cur_mapped;
                  bus_wdata <= cur_wide ? {wacc, rx_sr} : {8'h00, wacc[7:0], rx_sr};
                  adv       <= 1'b1;
                  adv_fetch <= 1'b0;
                end else begin
                  bi <= bi + 2'd1;
                end
              end
            endcase
          end
          ST_RX_ACK: begin
            sda_pull <= 1'b0;
            st       <= ST_RX;
          end
          ST_TX: begin
            if (byte_done) begin
              byte_done <= 1'b0;
              sda_pull  <= 1'b0;
              st        <= ST_TX_ACK;
            end else begin
              sda_pull <= ~tx_sr[6];
              tx_sr    <= {tx_sr[6:0], 1'b0};
            end
          end
          ST_TX_ACK: begin
            st       <= ST_TX;
            bit_cnt  <= '0;
            tx_sr    <= nxt_byte;
            sda_pull <= ~nxt_byte[7];
          end
          default: ;
        endcase
      end
    end
  end

  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re)); // R5
  AST_RE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> !bus_re); // R5
  AST_WE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> (bus_addr == $past(bus_addr) + ONE_A)); // R4
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull) && !$past(start_det) && !$past(stop_det)) |-> !scl_s); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_pull); // R7
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we || bus_re) |-> cur_mapped); // R8
endmodule

// File: tb/i2c_region_bridge_test.sv
module i2c_region_bridge_test;
  localparam int Q = 10;

  localparam logic [63:0] VEC [6] = '{
    {16'h0010, 24'hABCDEF, 24'h123456},
    {16'h0FFE, 24'h445566, 24'h00BEEF},
    {16'h1FFF, 24'h00CAFE, 24'h778899},
    {16'h200F, 24'h0A0B0C, 24'h00D00D},
    {16'h1234, 24'h001111, 24'h002222},
    {16'h3000, 24'h00AAAA, 24'h00BBBB}
  };

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_low = 1'b0, addr_pin = 1'b0;
  logic sda_pull, bus_we, bus_re, sda_line;
  logic [15:0] bus_addr;
  logic [23:0] bus_wdata, bus_rdata = '0;
  int checks = 0, errors = 0, viol = 0, wr_cnt = 0, rd_cnt = 0;
  logic [15:0] wl_a [16];
  logic [23:0] wl_d [16];
  logic pull_q = 1'b0, done = 1'b0;

  always #2.5ns clk = ~clk;
  assign sda_line = ~(m_low | sda_pull);

  i2c_region_bridge uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_pull(sda_pull), .addr_pin(addr_pin), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  function automatic int nbw(input logic [15:0] a);
    return (a <= 16'h0FFE || (a >= 16'h2000 && a <= 16'h200F)) ? 3 : 2;
  endfunction
  function automatic logic mapd(input logic [15:0] a);
    return a <= 16'h200F;
  endfunction
  function automatic logic [23:0] pat(input logic [15:0] a);
    return {a[7:0] ^ 8'h5C, a};
  endfunction
  function automatic logic [23:0] msk(input logic [23:0] d, input int n);
    return (n == 3) ? d : {8'h00, d[15:0]};
  endfunction

  // memory model and bus logs
  always @(posedge clk) begin
    if (bus_we) begin
      wl_a[wr_cnt[3:0]] <= bus_addr;
      wl_d[wr_cnt[3:0]] <= bus_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (bus_re) begin
      bus_rdata <= pat(bus_addr);
      rd_cnt <= rd_cnt + 1;
    end
    pull_q <= sda_pull;
    if (rst_n && (sda_pull !== pull_q) && m_scl) viol <= viol + 1;
  end

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #1ns;
  endtask

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic s);
    m_low = ~b;  hold(Q);
    m_scl = 1'b1; hold(Q);
    s = sda_line; hold(Q);
    m_scl = 1'b0; hold(Q);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_low = 1'b1; hold(Q);
    m_scl = 1'b0; hold(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; hold(Q);
    m_scl = 1'b1; hold(Q);
    m_low = 1'b0; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic ack);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      bit_io(1'b1, s);
      b = {b[6:0], s};
    end
    bit_io(~ack, s);
  endtask

  task automatic send_word(input logic [23:0] d, input int n, inout logic nak);
    logic ack;
    for (int i = n - 1; i >= 0; i--) begin
      send_byte(d[8*i +: 8], ack);
      if (!ack) nak = 1'b1;
    end
  endtask

  task automatic recv_word(output logic [23:0] d, input int n, input logic ack_last);
    logic [7:0] b;
    d = '0;
    for (int i = 0; i < n; i++) begin
      recv_byte(b, (i < n - 1) ? 1'b1 : ack_last);
      d = {d[15:0], b};
    end
  endtask

  task automatic set_addr(input logic [15:0] a, inout logic nak);
    logic ack;
    i2c_start();
    send_byte(8'h38, ack); if (!ack) nak = 1'b1;
    send_byte(a[15:8], ack); if (!ack) nak = 1'b1;
    send_byte(a[7:0], ack);  if (!ack) nak = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic nak, ack;
    logic [23:0] r0, r1;
    int wb, rb;

    hold(5);
    chk(sda_pull == 1'b0, "R11", "sda_pull in reset", 32'(sda_pull), 0);
    chk(bus_we == 1'b0 && bus_re == 1'b0, "R11", "strobes in reset",
        32'({bus_we, bus_re}), 0);
    rst_n = 1'b1;
    hold(5);

    // vector table: write two words then read them back
    for (int v = 0; v < 6; v++) begin
      logic [15:0] a, a1;
      logic [23:0] d0, d1;
      int idx;
      a  = VEC[v][63:48];
      d0 = VEC[v][47:24];
      d1 = VEC[v][23:0];
      a1 = a + 16'd1;
      nak = 1'b0;
      wb = wr_cnt;
      set_addr(a, nak);
      send_word(d0, nbw(a), nak);
      send_word(d1, nbw(a1), nak);
      i2c_stop();
      hold(4);
      chk(!nak, "R8", "all write bytes acked", 32'(nak), 0);
      chk(wr_cnt - wb == int'(mapd(a)) + int'(mapd(a1)), "R4", "write strobe count",
          32'(wr_cnt - wb), 32'(int'(mapd(a)) + int'(mapd(a1))));
      idx = wb;
      if (mapd(a)) begin
        chk(wl_a[idx[3:0]] == a, "R2", "first word address", 32'(wl_a[idx[3:0]]), 32'(a));
        chk(wl_d[idx[3:0]] == msk(d0, nbw(a)), "R3", "first word data",
            32'(wl_d[idx[3:0]]), 32'(msk(d0, nbw(a))));
        idx++;
      end
      if (mapd(a1)) begin
        chk(wl_a[idx[3:0]] == a1, "R4", "advanced address", 32'(wl_a[idx[3:0]]), 32'(a1));
        chk(wl_d[idx[3:0]] == msk(d1, nbw(a1)), "R3", "second word data",
            32'(wl_d[idx[3:0]]), 32'(msk(d1, nbw(a1))));
      end

      nak = 1'b0;
      rb = rd_cnt;
      set_addr(a, nak);
      i2c_start();
      send_byte(8'h39, ack);
      recv_word(r0, nbw(a), 1'b1);
      recv_word(r1, nbw(a1), 1'b0);
      i2c_stop();
      hold(4);
      chk(ack && !nak, "R1", "read address acked", 32'({ack, nak}), 32'h2);
      chk(r0 == (mapd(a) ? msk(pat(a), nbw(a)) : 24'h0), "R5", "first read word",
          32'(r0), 32'(mapd(a) ? msk(pat(a), nbw(a)) : 24'h0));
      chk(r1 == (mapd(a1) ? msk(pat(a1), nbw(a1)) : 24'h0), "R6", "second read word",
          32'(r1), 32'(mapd(a1) ? msk(pat(a1), nbw(a1)) : 24'h0));
      chk(rd_cnt - rb == int'(mapd(a)) + int'(mapd(a1)), "R8", "read request count",
          32'(rd_cnt - rb), 32'(int'(mapd(a)) + int'(mapd(a1))));
    end

    // R1: device address follows addr_pin
    wb = wr_cnt;
    i2c_start(); send_byte(8'h3A, ack); i2c_stop();
    chk(!ack, "R1", "0x3A ignored with pin low", 32'(ack), 0);
    addr_pin = 1'b1;
    hold(4);
    i2c_start(); send_byte(8'h38, ack); i2c_stop();
    chk(!ack, "R1", "0x38 ignored with pin high", 32'(ack), 0);
    nak = 1'b0;
    i2c_start(); send_byte(8'h3A, ack);
    send_byte(8'h00, ack); send_byte(8'h05, ack);
    send_word(24'h112233, 3, nak);
    i2c_stop();
    hold(4);
    chk(wr_cnt - wb == 1, "R1", "write via alternate address", 32'(wr_cnt - wb), 1);
    chk(wl_d[wb[3:0]] == 24'h112233 && wl_a[wb[3:0]] == 16'h0005, "R1",
        "alternate address write data", 32'(wl_d[wb[3:0]]), 32'h112233);
    addr_pin = 1'b0;
    hold(4);

    // R7: NACK ends the read
    nak = 1'b0;
    rb = rd_cnt;
    set_addr(16'h1000, nak);
    i2c_start(); send_byte(8'h39, ack);
    recv_word(r0, 2, 1'b0);
    hold(4);
    chk(sda_pull == 1'b0, "R7", "SDA released after NACK", 32'(sda_pull), 0);
    i2c_stop();
    hold(40);
    chk(rd_cnt - rb == 1, "R7", "no fetch after NACK", 32'(rd_cnt - rb), 1);
    chk(r0 == {8'h00, pat(16'h1000)[15:0]}, "R5", "16-bit read word",
        32'(r0), 32'({8'h00, pat(16'h1000)[15:0]}));

    // R9: STOP and repeated START abort a partial word
    wb = wr_cnt;
    nak = 1'b0;
    set_addr(16'h0040, nak);
    send_byte(8'hAA, ack);
    i2c_stop();
    hold(4);
    chk(wr_cnt == wb, "R9", "STOP drops partial word", 32'(wr_cnt - wb), 0);
    rb = rd_cnt;
    set_addr(16'h0020, nak);
    send_byte(8'hAA, ack); send_byte(8'hBB, ack);
    i2c_start(); send_byte(8'h39, ack);
    recv_word(r0, 3, 1'b0);
    i2c_stop();
    hold(4);
    chk(wr_cnt == wb, "R9", "repeated START drops partial word", 32'(wr_cnt - wb), 0);
    chk(r0 == pat(16'h0020), "R9", "address kept after abort", 32'(r0), 32'(pat(16'h0020)));
    chk(rd_cnt - rb == 1, "R9", "single fetch after abort", 32'(rd_cnt - rb), 1);

    chk(viol == 0, "R10", "SDA changes while SCL high", 32'(viol), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule